// File: doc/BRIEF.md
# Debug Bus Access Comparator

This block watches a CPU system bus and pulses one of three match outputs when a programmed access occurs. Channels A and B are full channels. Each compares the bus address and can also require a given read/write direction, a given access size and a given data value. Channel C is a reduced channel: it compares the address and, if asked to, the direction. Address equality is exact. A word access that starts one byte below the programmed address touches that byte, but it is not a match.

Each channel can instead run in tagged mode. In tagged mode an opcode fetch from the programmed address arms the channel. The match fires only when the execute stage later reports that same address. A small per-channel queue holds the armed fetches until they execute. A pipeline flush empties the queue. The configuration arrives on static input ports, which a debug controller drives.

Top module: `dbg_access_cmp`

## Requirements
- R1: After reset all three match outputs are 0 and every tag queue is empty.
- R2: An untagged, enabled channel pulses its match output in the cycle after a `busValid` cycle only when `busAddr` equals its programmed address exactly. A word access at the programmed address minus one never matches.
- R3: With `cfgDirEn[i]` = 0 both reads and writes qualify. With `cfgDirEn[i]` = 1 only an access whose `busRead` equals `cfgDirRead[i]` qualifies (1 = read). This applies to all three channels.
- R4: On channels A and B, `cfgSizeEn` = 1 requires `busWord` to equal `cfgSizeWord` (1 = word, 0 = byte). Channel C ignores the access size.
- R5: On channels A and B, `cfgDataEn` = 1 requires a data match. A word access compares all 16 bits of `busData`. A byte access compares only bits 7:0 of `busData` against bits 7:0 of the channel's compare value. Channel C ignores the data.
- R6: A channel whose `cfgEnable` bit is 0 never pulses. Disabling a tagged channel discards its armed entries.
- R7: A tagged channel arms on a `busValid` cycle with `busFetch` = 1 at its programmed address. Direction, size and data settings are ignored. It produces no match at fetch time. It pulses in the cycle after an `exValid` cycle whose `exAddr` equals the oldest armed entry, and that entry is then retired.
- R8: The tag queue holds `TAG_DEPTH` entries (3 by default) in fetch order. A fetch that arrives while the queue is full is dropped. `pipeFlush` empties the queue, and no tagged match or arming happens in a flush cycle.
- R9: Output bit 0 belongs to channel A, bit 1 to B and bit 2 to C. Every qualifying event gives a pulse one cycle wide.
- R10: An untagged channel never pulses after a cycle with `busValid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe |
| busAddr | input | ADDR_W | Bus address |
| busData | input | DATA_W | Bus data |
| busRead | input | 1 | 1 = read, 0 = write |
| busWord | input | 1 | 1 = word access, 0 = byte access |
| busFetch | input | 1 | Access is an opcode fetch |
| exValid | input | 1 | An instruction enters the execute stage |
| exAddr | input | ADDR_W | Opcode address of the executing instruction |
| pipeFlush | input | 1 | Pipeline flush, empties the tag queues |
| cfgEnable | input | 3 | Per-channel enable |
| cfgTag | input | 3 | Per-channel tagged mode |
| cfgDirEn | input | 3 | Per-channel direction qualifier enable |
| cfgDirRead | input | 3 | Direction that qualifies (1 = read) |
| cfgSizeEn | input | 2 | Size qualifier enable, channels A and B |
| cfgSizeWord | input | 2 | Size that qualifies (1 = word) |
| cfgDataEn | input | 2 | Data qualifier enable, channels A and B |
| cfgAddr | input | 3*ADDR_W | Programmed addresses, channel A in the low bits |
| cfgData | input | 2*DATA_W | Data compare values, channel A in the low bits |
| match | output | 3 | Match pulses, bit 0 = A, bit 1 = B, bit 2 = C |

## Verification
The embedded assertions check four things on every cycle. A disabled channel stays silent. An untagged channel stays silent after a cycle without a bus strobe. A tagged channel stays silent after a cycle without an executing instruction. Queue occupancy stays within its depth, never pops empty, never overflows, and clears after a flush or a disable.

Only the bench's scenarios can show the rest. These are the exact qualifier combinations over an exhaustive sweep of the enables, directions, sizes and data differences, and the rejection of the overlapping word access. They also cover the fetch-order release of tagged entries, dropping on a full queue, and the mapping of each channel to its output bit.

// File: rtl/dbgcmp_pkg.sv
package dbgcmp_pkg;
  localparam int NUM_CH   = 3;
  localparam int NUM_FULL = 2;

  // strobes issued by control to the datapath tag queues
  typedef struct packed {
    logic [NUM_CH-1:0] push;
    logic [NUM_CH-1:0] pop;
    logic [NUM_CH-1:0] clear;
  } tagStrobes_t;

  // comparison results returned by the datapath
  typedef struct packed {
    logic [NUM_CH-1:0] busHit;
    logic [NUM_CH-1:0] fetchHit;
    logic [NUM_CH-1:0] headHit;
    logic [NUM_CH-1:0] tagFull;
    logic [NUM_CH-1:0] tagEmpty;
  } cmpFlags_t;
endpackage

// File: rtl/dbgcmp_datapath.sv
module dbgcmp_datapath import dbgcmp_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int TAG_DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busData,
  input  logic                       busRead,
  input  logic                       busWord,
  input  logic [ADDR_W-1:0]          exAddr,
  input  logic [NUM_CH-1:0]          cfgDirEn,
  input  logic [NUM_CH-1:0]          cfgDirRead,
  input  logic [NUM_FULL-1:0]        cfgSizeEn,
  input  logic [NUM_FULL-1:0]        cfgSizeWord,
  input  logic [NUM_FULL-1:0]        cfgDataEn,
  input  logic [NUM_CH*ADDR_W-1:0]   cfgAddr,
  input  logic [NUM_FULL*DATA_W-1:0] cfgData,
  input  tagStrobes_t                strobes,
  output cmpFlags_t                  flags
);
  localparam int CNT_W  = $clog2(TAG_DEPTH + 1);
  localparam int BYTE_W = DATA_W / 2;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [ADDR_W-1:0] chAddr;
    logic              addrEq;
    logic              dirOk;
    assign chAddr = cfgAddr[ch*ADDR_W +: ADDR_W];
    assign addrEq = (busAddr == chAddr);
    assign dirOk  = !cfgDirEn[ch] || (busRead == cfgDirRead[ch]);
    assign flags.fetchHit[ch] = addrEq;

    if (ch < NUM_FULL) begin : g_full
      logic [DATA_W-1:0] chData;
      logic              sizeOk;
      logic              dataOk;
      assign chData = cfgData[ch*DATA_W +: DATA_W];
      assign sizeOk = !cfgSizeEn[ch] || (busWord == cfgSizeWord[ch]);
      assign dataOk = !cfgDataEn[ch] ||
                      (busWord ? (busData == chData)
                               : (busData[BYTE_W-1:0] == chData[BYTE_W-1:0]));
      assign flags.busHit[ch] = addrEq && dirOk && sizeOk && dataOk;
    end else begin : g_reduced
      assign flags.busHit[ch] = addrEq && dirOk;
    end

    // tag queue: slot 0 holds the oldest armed opcode address
    logic [TAG_DEPTH*ADDR_W-1:0] tagSlots;
    logic [CNT_W-1:0]            tagCount;
    logic [CNT_W-1:0]            wrIdx;
    assign wrIdx = strobes.pop[ch] ? tagCount - CNT_W'(1) : tagCount;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  tagCount <= '0;
      else if (strobes.clear[ch]) tagCount <= '0;
      else tagCount <= tagCount + CNT_W'(strobes.push[ch]) - CNT_W'(strobes.pop[ch]);
    end

    always_ff @(posedge clk) begin
      if (strobes.pop[ch]) tagSlots <= tagSlots >> ADDR_W;
      if (strobes.push[ch]) begin
        for (int k = 0; k < TAG_DEPTH; k++) begin
          if (wrIdx == CNT_W'(k)) tagSlots[k*ADDR_W +: ADDR_W] <= busAddr;
        end
      end
    end

    assign flags.tagEmpty[ch] = (tagCount == '0);
    assign flags.tagFull[ch]  = (tagCount == CNT_W'(TAG_DEPTH));
    assign flags.headHit[ch]  = (tagCount != '0) && (exAddr == tagSlots[ADDR_W-1:0]);

    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
      tagCount <= CNT_W'(TAG_DEPTH));
    assert_pop_has_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobes.pop[ch] |-> tagCount != '0);
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.push[ch] && flags.tagFull[ch]) |-> strobes.pop[ch]);
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clear[ch] |=> tagCount == '0);
  end
endmodule

// File: rtl/dbgcmp_ctrl.sv
module dbgcmp_ctrl import dbgcmp_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busFetch,
  input  logic              exValid,
  input  logic              pipeFlush,
  input  logic [NUM_CH-1:0] cfgEnable,
  input  logic [NUM_CH-1:0] cfgTag,
  input  cmpFlags_t         flags,
  output tagStrobes_t       strobes,
  output logic [NUM_CH-1:0] matchQ
);
  logic [NUM_CH-1:0] matchNext;

  always_comb begin
    strobes   = '0;
    matchNext = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      strobes.clear[ch] = pipeFlush || !(cfgEnable[ch] && cfgTag[ch]);
      strobes.pop[ch]   = !strobes.clear[ch] && exValid && flags.headHit[ch];
      strobes.push[ch]  = !strobes.clear[ch] && busValid && busFetch &&
                          flags.fetchHit[ch] && (!flags.tagFull[ch] || strobes.pop[ch]);
      matchNext[ch]     = cfgEnable[ch] &&
                          (cfgTag[ch] ? strobes.pop[ch] : (busValid && flags.busHit[ch]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= '0;
    else       matchQ <= matchNext;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
      !cfgEnable[ch] |=> !matchQ[ch]);
    assert_strobe_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgTag[ch] && !busValid) |=> !matchQ[ch]);
    assert_tag_waits_exec_R7: assert property (@(posedge clk) disable iff (!rstN)
      (cfgTag[ch] && !exValid) |=> !matchQ[ch]);
  end
endmodule

// File: rtl/dbg_access_cmp.sv
module dbg_access_cmp import dbgcmp_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int TAG_DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busValid,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busData,
  input  logic                       busRead,
  input  logic                       busWord,
  input  logic                       busFetch,
  input  logic                       exValid,
  input  logic [ADDR_W-1:0]          exAddr,
  input  logic                       pipeFlush,
  input  logic [NUM_CH-1:0]          cfgEnable,
  input  logic [NUM_CH-1:0]          cfgTag,
  input  logic [NUM_CH-1:0]          cfgDirEn,
  input  logic [NUM_CH-1:0]          cfgDirRead,
  input  logic [NUM_FULL-1:0]        cfgSizeEn,
  input  logic [NUM_FULL-1:0]        cfgSizeWord,
  input  logic [NUM_FULL-1:0]        cfgDataEn,
  input  logic [NUM_CH*ADDR_W-1:0]   cfgAddr,
  input  logic [NUM_FULL*DATA_W-1:0] cfgData,
  output logic [NUM_CH-1:0]          match
);
  tagStrobes_t strobes;
  cmpFlags_t   flags;

  dbgcmp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_DEPTH(TAG_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .busRead(busRead), .busWord(busWord), .exAddr(exAddr),
    .cfgDirEn(cfgDirEn), .cfgDirRead(cfgDirRead), .cfgSizeEn(cfgSizeEn),
    .cfgSizeWord(cfgSizeWord), .cfgDataEn(cfgDataEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .strobes(strobes), .flags(flags)
  );

  dbgcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busFetch(busFetch),
    .exValid(exValid), .pipeFlush(pipeFlush), .cfgEnable(cfgEnable),
    .cfgTag(cfgTag), .flags(flags), .strobes(strobes), .matchQ(match)
  );
endmodule

// File: tb/dbg_access_cmp_bench.sv
module dbg_access_cmp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [AW-1:0] BASE = 16'h4A52;
  localparam logic [AW-1:0] TADR = 16'h0812;
  localparam logic [DW-1:0] CDAT = 16'hC35A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 0, busRead = 0, busWord = 0, busFetch = 0, exValid = 0, pipeFlush = 0;
  logic [AW-1:0] busAddr = '0, exAddr = '0;
  logic [DW-1:0] busData = '0;
  logic [2:0] cfgEnable = '0, cfgTag = '0, cfgDirEn = '0, cfgDirRead = '0;
  logic [1:0] cfgSizeEn = '0, cfgSizeWord = '0, cfgDataEn = '0;
  logic [3*AW-1:0] cfgAddr = '0;
  logic [2*DW-1:0] cfgData = '0;
  logic [2:0] match;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_access_cmp u_dbg_access_cmp (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busRead(busRead), .busWord(busWord), .busFetch(busFetch), .exValid(exValid),
    .exAddr(exAddr), .pipeFlush(pipeFlush), .cfgEnable(cfgEnable), .cfgTag(cfgTag),
    .cfgDirEn(cfgDirEn), .cfgDirRead(cfgDirRead), .cfgSizeEn(cfgSizeEn),
    .cfgSizeWord(cfgSizeWord), .cfgDataEn(cfgDataEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .match(match)
  );

  task automatic check(input logic [2:0] exp, input string req);
    vectors++;
    if (match !== exp) begin
      fails++;
      $display("FAIL %s: match=%b expected %b", req, match, exp);
    end
  endtask

  // one bus access at a negedge, result sampled at the following negedge
  task automatic busCycle(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rd,
                          input logic wd, input logic fe, input logic [2:0] exp, input string req);
    busValid = 1; busAddr = a; busData = d; busRead = rd; busWord = wd; busFetch = fe;
    @(negedge clk);
    busValid = 0; busFetch = 0;
    check(exp, req);
  endtask

  task automatic exCycle(input logic [AW-1:0] a, input logic [2:0] exp, input string req);
    exValid = 1; exAddr = a;
    @(negedge clk);
    exValid = 0;
    check(exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: match=%b expected completion", match);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(3'b000, "R1 reset");
    rstN = 1;
    @(negedge clk);
    check(3'b000, "R1 after release");

    // exhaustive qualifier sweep, untagged, all channels on BASE
    cfgEnable = 3'b111; cfgTag = 3'b000;
    cfgAddr = {BASE, BASE, BASE};
    cfgData = {CDAT, CDAT};
    for (int cb = 0; cb < 32; cb++) begin
      cfgDirEn = {3{cb[0]}}; cfgDirRead = {3{cb[1]}};
      cfgSizeEn = {2{cb[2]}}; cfgSizeWord = {2{cb[3]}}; cfgDataEn = {2{cb[4]}};
      for (int off = 0; off < 3; off++) begin
        for (int rd = 0; rd < 2; rd++) begin
          for (int wd = 0; wd < 2; wd++) begin
            for (int dv = 0; dv < 3; dv++) begin
              logic [AW-1:0] a;
              logic [DW-1:0] d;
              logic aEq, dirOk, sizeOk, dataOk, fullHit, redHit;
              a = BASE - 16'd1 + AW'(off);
              d = (dv == 0) ? CDAT : (dv == 1) ? (CDAT ^ 16'h0100) : (CDAT ^ 16'h0001);
              aEq = (off == 1);
              dirOk = !cb[0] || (rd[0] == cb[1]);
              sizeOk = !cb[2] || (wd[0] == cb[3]);
              dataOk = !cb[4] || (wd[0] ? (d == CDAT) : (d[7:0] == CDAT[7:0]));
              fullHit = aEq && dirOk && sizeOk && dataOk;
              redHit = aEq && dirOk;
              busCycle(a, d, rd[0], wd[0], 1'b0, {redHit, fullHit, fullHit},
                       "R2 R3 R4 R5 qualifier sweep");
            end
          end
        end
      end
    end

    // R10: address present but no strobe
    cfgDirEn = '0; cfgSizeEn = '0; cfgDataEn = '0;
    busAddr = BASE; busValid = 0;
    @(negedge clk);
    check(3'b000, "R10 no strobe");

    // R6: every enable pattern
    for (int en = 0; en < 8; en++) begin
      cfgEnable = en[2:0];
      busCycle(BASE, CDAT, 1'b1, 1'b1, 1'b0, en[2:0], "R6 enable gating");
    end
    cfgEnable = 3'b111;

    // R9: distinct addresses map one bit each
    cfgAddr = {16'h0300, 16'h0200, 16'h0100};
    for (int ch = 0; ch < 3; ch++) begin
      busCycle(16'h0100 * AW'(ch + 1), CDAT, 1'b0, 1'b0, 1'b0, 3'b001 << ch, "R9 channel mapping");
    end
    busCycle(16'h0100, CDAT, 1'b1, 1'b0, 1'b0, 3'b001, "R9 pulse");
    @(negedge clk);
    check(3'b000, "R9 single-cycle pulse");

    // tagged channel A, untagged B and C, read-only direction on all
    cfgAddr = {TADR, TADR, TADR};
    cfgTag = 3'b001; cfgDirEn = 3'b111; cfgDirRead = 3'b111;
    @(negedge clk);
    for (int i = 0; i < 4; i++) busCycle(TADR, CDAT, 1'b1, 1'b1, 1'b1, 3'b110, "R7 R8 fetch arms");
    exCycle(TADR, 3'b001, "R7 exec release 1");
    exCycle(TADR, 3'b001, "R8 exec release 2");
    exCycle(TADR, 3'b001, "R8 exec release 3");
    exCycle(TADR, 3'b000, "R8 fourth fetch dropped");

    // qualifiers ignored in tagged mode
    cfgDirRead = 3'b000;
    busCycle(TADR, 16'h0000, 1'b1, 1'b0, 1'b1, 3'b000, "R7 fetch read vs write-only");
    exCycle(TADR, 3'b001, "R7 qualifiers ignored");

    busCycle(TADR + 16'd2, CDAT, 1'b1, 1'b1, 1'b1, 3'b000, "R7 other fetch");
    exCycle(TADR, 3'b000, "R7 nothing armed");
    busCycle(TADR, CDAT, 1'b0, 1'b1, 1'b0, 3'b110, "R7 non-fetch write");
    exCycle(TADR, 3'b000, "R7 data access does not arm");

    busCycle(TADR, CDAT, 1'b1, 1'b1, 1'b1, 3'b000, "R7 arm");
    exCycle(TADR + 16'd4, 3'b000, "R7 other exec");
    exCycle(TADR, 3'b001, "R7 matching exec");

    busCycle(TADR, CDAT, 1'b1, 1'b1, 1'b1, 3'b000, "R8 arm 1");
    busCycle(TADR, CDAT, 1'b1, 1'b1, 1'b1, 3'b000, "R8 arm 2");
    pipeFlush = 1;
    @(negedge clk);
    pipeFlush = 0;
    check(3'b000, "R8 flush cycle");
    exCycle(TADR, 3'b000, "R8 flush emptied queue");

    busCycle(TADR, CDAT, 1'b1, 1'b1, 1'b1, 3'b000, "R6 arm");
    cfgEnable = 3'b110;
    @(negedge clk);
    check(3'b000, "R6 disabled");
    cfgEnable = 3'b111;
    exCycle(TADR, 3'b000, "R6 disable discards entries");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule